// File: doc/BRIEF.md
# Two-Edge Reciprocal Period Meter

This block measures the spacing between two successive rising edges of an unknown, asynchronous input, in ticks of a free-running base count that a shared timebase elsewhere on the chip provides. Software or a controlling block pulses an arm request. The meter then waits for a first rising edge and latches the base count there. It waits for a second rising edge, latches the base count again and reports the difference. After that it stops capturing and holds the result until it is armed again.

The unknown input first goes through a synchronizer and a majority-free noise filter. The filter samples the synchronized level once every few clocks and accepts a new level only when a run of consecutive samples all agree. Short spikes and dropouts never reach edge detection. The difference is taken modulo the width of the base count, so a wrap of the timebase between the two edges still yields the true count.

Top module: `recip_period_meter`

## Requirements
- R1: After reset the step output reads 3 (idle), done is low and the tick result is zero. In idle, input edges change nothing until the first arm request.
- R2: An arm request moves the step to 0 (waiting for the first edge) in the next cycle from any step, including step 1. A rising edge that the filter presents in the same cycle as the arm request is discarded.
- R3: In step 0, a filtered rising edge latches the base count as the start value and moves the step to 1.
- R4: In step 1, the next filtered rising edge latches the base count as the stop value, moves the step to 2 and publishes the tick result.
- R5: The tick result equals stop minus start modulo 2^CNT_W, so it is correct when the base count wraps between the two edges.
- R6: In step 2, further input edges are ignored: the step, the tick result and the stop value hold until the next arm request.
- R7: The filter takes one sample every SAMPLE_DIV clocks. It changes its output level only after FILT_LEN consecutive samples agree, so a pulse or dropout shorter than SAMPLE_DIV clocks never counts as an edge.
- R8: The done output is high exactly when the step output reads 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle request to start a new measurement |
| sig_i | input | 1 | Unknown asynchronous input whose period is measured |
| base_count_i | input | CNT_W | Free-running base count from the shared timebase |
| step_o | output | 2 | Measurement step: 0 first edge, 1 second edge, 2 done, 3 idle |
| done_o | output | 1 | High while a finished result is held |
| ticks_o | output | CNT_W | Base-count ticks between the two captured edges |

## Verification
The assertions assume that arm_i is a clean synchronous pulse and that base_count_i is any value that changes on clock edges. They put no limit on how the count progresses, because the wrap check only compares latched values. The bench advances the base count by one every cycle and presets it close to the top of its range for the wrap case. It drives the unknown input with high and low phases of random length that are multiples of the sample interval and well above the filter length. This keeps both edges of a measurement at the same sampling phase, so the expected result is simply the number of cycles between the driven edges. Deliberate three-cycle glitches are the only stimulus shorter than one sample interval.

// File: rtl/recip_pkg.sv
package recip_pkg;

    // Step encoding of the measurement sequence; values are visible on step_o.
    typedef enum logic [1:0] {
        STEP_FIRST  = 2'd0,
        STEP_SECOND = 2'd1,
        STEP_DONE   = 2'd2,
        STEP_IDLE   = 2'd3
    } step_e;

endpackage

// File: rtl/recip_glitch_filter.sv
module recip_glitch_filter #(
    parameter int SAMPLE_DIV  = 4,
    parameter int FILT_LEN    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic level_o
);

    localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [DIV_W-1:0]       div;
        logic [FILT_LEN-1:0]    hist;
        logic                   level;
    } filt_t;

    filt_t q, d;
    logic  sample_en;
    logic  sync_out;

    assign sync_out = q.sync[SYNC_STAGES-1];

    // Sampling strobe: one pulse every SAMPLE_DIV clocks.
    generate
        if (SAMPLE_DIV > 1) begin : g_div
            assign sample_en = (q.div == DIV_LAST);
        end else begin : g_nodiv
            assign sample_en = 1'b1;
        end
    endgenerate

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], sig_i};
        d.div  = sample_en ? '0 : q.div + 1'b1;
        if (sample_en) begin
            d.hist = {q.hist[FILT_LEN-2:0], sync_out};
            if (&d.hist) begin
                d.level = 1'b1;
            end else if (~|d.hist) begin
                d.level = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign level_o = q.level;

    // The accepted level may only move in the cycle after a sample strobe.
    AST_LEVEL_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.level != $past(q.level)) |-> $past(sample_en)); // R7

    // A level change is always backed by the sampled history in agreement.
    AST_LEVEL_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.level) |-> $past(sync_out)); // R7

endmodule

// File: rtl/recip_edge_capture.sv
module recip_edge_capture
    import recip_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             level_i,
    input  logic [CNT_W-1:0] base_i,
    output step_e            step_o,
    output logic             done_o,
    output logic [CNT_W-1:0] ticks_o
);

    typedef struct packed {
        step_e            step;
        logic             prev;
        logic [CNT_W-1:0] start;
        logic [CNT_W-1:0] stop;
        logic [CNT_W-1:0] ticks;
    } cap_t;

    cap_t q, d;
    logic rise;

    assign rise = level_i & ~q.prev;

    always_comb begin
        d      = q;
        d.prev = level_i;
        if (arm_i) begin
            // Restart from any step; an edge in this cycle is dropped.
            d.step = STEP_FIRST;
        end else if (rise) begin
            unique case (q.step)
                STEP_FIRST: begin
                    d.start = base_i;
                    d.step  = STEP_SECOND;
                end
                STEP_SECOND: begin
                    d.stop  = base_i;
                    d.ticks = base_i - q.start;
                    d.step  = STEP_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.step  <= STEP_IDLE;
            q.prev  <= 1'b0;
            q.start <= '0;
            q.stop  <= '0;
            q.ticks <= '0;
        end else begin
            q <= d;
        end
    end

    assign step_o  = q.step;
    assign done_o  = (q.step == STEP_DONE);
    assign ticks_o = q.ticks;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.step == STEP_IDLE && !arm_i) |=> (q.step == STEP_IDLE)); // R1

    AST_ARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (q.step == STEP_FIRST)); // R2

    AST_START_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!arm_i && rise && q.step == STEP_FIRST)
        |=> (q.step == STEP_SECOND && q.start == $past(base_i))); // R3

    AST_DONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(q.step) == STEP_SECOND)); // R4

    AST_TICKS_MODULO: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (q.ticks == q.stop - q.start)); // R5

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !arm_i) |=> (done_o && $stable(q.ticks) && $stable(q.stop))); // R6

endmodule

// File: rtl/recip_period_meter.sv
module recip_period_meter
    import recip_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int SAMPLE_DIV = 4,
    parameter int FILT_LEN   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             sig_i,
    input  logic [CNT_W-1:0] base_count_i,
    output logic [1:0]       step_o,
    output logic             done_o,
    output logic [CNT_W-1:0] ticks_o
);

    logic  level_q;
    step_e step_q;

    recip_glitch_filter #(
        .SAMPLE_DIV (SAMPLE_DIV),
        .FILT_LEN   (FILT_LEN),
        .SYNC_STAGES(2)
    ) i_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (sig_i),
        .level_o(level_q)
    );

    recip_edge_capture #(
        .CNT_W(CNT_W)
    ) i_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (arm_i),
        .level_i(level_q),
        .base_i (base_count_i),
        .step_o (step_q),
        .done_o (done_o),
        .ticks_o(ticks_o)
    );

    assign step_o = step_q;

    // Done and step come from separate decode paths at the boundary.
    AST_DONE_MATCHES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (step_o == 2'd2)); // R8

endmodule

// File: tb/test_recip_period_meter.sv
module test_recip_period_meter;

    localparam int CNT_W = 32;
    localparam int LIMIT = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm = 1'b0;
    logic             sig = 1'b0;
    logic [CNT_W-1:0] base_cnt = '0;
    logic             preset_req = 1'b0;
    logic [CNT_W-1:0] preset_val = '0;
    logic [1:0]       step;
    logic             done;
    logic [CNT_W-1:0] ticks;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    recip_period_meter i_recip_period_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm),
        .sig_i       (sig),
        .base_count_i(base_cnt),
        .step_o      (step),
        .done_o      (done),
        .ticks_o     (ticks)
    );

    // Free-running timebase, advanced away from the sampling edge.
    always @(negedge clk) begin
        if (preset_req) base_cnt <= preset_val;
        else            base_cnt <= base_cnt + 1'b1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > LIMIT) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [CNT_W-1:0] expect_ticks(input logic [CNT_W-1:0] t_start,
                                                      input logic [CNT_W-1:0] t_stop);
        return t_stop - t_start;
    endfunction

    task automatic check(input string req, input logic [CNT_W-1:0] act,
                         input logic [CNT_W-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    // One full measurement: high phase h, low phase l, optional short glitch.
    task automatic measure(input int h, input int l, input bit glitch);
        logic [CNT_W-1:0] t1, t2;
        pulse_arm();
        wait_cyc(8);
        check("R2 armed step", CNT_W'(step), 0);
        sig = 1'b1;
        t1  = base_cnt;
        wait_cyc(36);
        check("R3 step after first edge", CNT_W'(step), 1);
        wait_cyc(h - 36);
        sig = 1'b0;
        if (glitch) begin
            wait_cyc(l / 2);
            sig = 1'b1;
            wait_cyc(3);
            sig = 1'b0;
            wait_cyc(l - l / 2 - 3);
            check("R7 glitch kept step 1", CNT_W'(step), 1);
        end else begin
            wait_cyc(l);
        end
        sig = 1'b1;
        t2  = base_cnt;
        wait_cyc(40);
        check("R4 done flag", CNT_W'(done), 1);
        check("R8 step reads 2 with done", CNT_W'(step), 2);
        check("R4 R5 ticks", ticks, expect_ticks(t1, t2));
        check("R4 ticks equal period", ticks, CNT_W'(h + l));
        sig = 1'b0;
        wait_cyc(40);
    endtask

    initial begin
        logic [CNT_W-1:0] held;
        void'($urandom(32'd20240611));
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1: reset state and idle ignores edges
        check("R1 reset step", CNT_W'(step), 3);
        check("R1 reset done", CNT_W'(done), 0);
        check("R1 reset ticks", ticks, 0);
        sig = 1'b1; wait_cyc(40); sig = 1'b0; wait_cyc(40);
        sig = 1'b1; wait_cyc(40); sig = 1'b0; wait_cyc(40);
        check("R1 idle step after edges", CNT_W'(step), 3);
        check("R8 idle done low", CNT_W'(done), 0);

        // R7: short pulse before the first edge is not an edge
        pulse_arm();
        wait_cyc(4);
        sig = 1'b1; wait_cyc(3); sig = 1'b0;
        wait_cyc(40);
        check("R7 short pulse ignored", CNT_W'(step), 0);

        // R2: re-arm while waiting for the second edge
        sig = 1'b1;
        wait_cyc(40);
        check("R3 first edge step", CNT_W'(step), 1);
        pulse_arm();
        check("R2 rearm in step 1", CNT_W'(step), 0);
        wait_cyc(20);
        check("R2 held level is no new edge", CNT_W'(step), 0);
        sig = 1'b0;
        wait_cyc(40);

        // Directed measurement with a low-phase glitch
        measure(48, 96, 1'b1);

        // R6: edges after completion are ignored
        held = ticks;
        sig = 1'b1; wait_cyc(40); sig = 1'b0; wait_cyc(40);
        check("R6 ticks held", ticks, held);
        check("R6 step held", CNT_W'(step), 2);

        // R5: base count wraps between the edges
        @(posedge clk);
        preset_val = 32'hFFFF_FF80;
        preset_req = 1'b1;
        @(posedge clk);
        preset_req = 1'b0;
        measure(64, 128, 1'b0);

        // Random periods, aligned to the sample interval
        for (int k = 0; k < 24; k++) begin
            int h, l;
            h = 4 * (10 + int'($urandom_range(0, 14)));
            l = 4 * (10 + int'($urandom_range(0, 40)));
            measure(h, l, k[2]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule